// File: doc/BRIEF.md
# CORDIC Quadrature IF Modulator

This block moves a complex baseband sample stream onto a real intermediate-frequency carrier. It runs at the output sample rate, with one I/Q pair accepted per clock while the input is flagged valid. For a 70 MHz carrier at a 200 MHz sample clock, the upper image of the converted signal lies near 130 MHz. The upstream chain has already interpolated the OFDM baseband by a total factor of ten, from 20 MS/s.

A 32-bit phase accumulator advances by a programmable tuning word on every accepted sample. The block rotates each input vector by the accumulated angle and emits only the real part of the result. The rotation is a pipelined CORDIC: the two most significant phase bits first apply a rotation by a whole number of quarter turns, and twelve micro-rotation stages then resolve the remaining angle in the range 0 to 90 degrees. There is no sine/cosine table and no complex multiplier. One constant multiplier removes the fixed CORDIC gain. The result is rounded and clamped to a 10-bit output. A valid flag travels through the pipeline with the data, so the latency is fixed.

Top module: `cordic_if_mixer`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `out_valid` is 0 and `out_data` is 0. Asserting reset in the middle of a stream clears both outputs at once, and it also sets the phase accumulator back to 0.
- R2: For an accepted sample (I, Q) with accumulator value P, the output is the two's-complement value round(4·(I·cos θ − Q·sin θ)) with θ = 2π·P/2^32. This holds within ±2 LSB over all input values.
- R3: After reset, the first accepted sample uses P = 0. Each accepted sample then adds the `ftw` value present on that same clock edge to P, modulo 2^32.
- R4: In a cycle with `in_valid` low, the phase does not advance and no output is produced. `out_data` keeps its previous value in every cycle where `out_valid` is low.
- R5: Each accepted sample produces exactly one output, and outputs leave in input order. `out_valid` is high exactly STAGES+2 clock edges after the edge that accepted the sample, where the accepting edge counts as the first.
- R6: A result above +511 is output as +511, and a result below −512 is output as −512.
- R7: Phase bits [31:30] choose a rotation of 0, 90, 180 or 270 degrees, so P = q·2^30 gives the exact quarter-turn result for q = 0 to 3.
- R8: A change of `ftw` affects only the phase step taken at the edge where the new value is sampled. Samples accepted earlier keep their phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_i | input | DATA_W | In-phase input, two's complement |
| in_q | input | DATA_W | Quadrature input, two's complement |
| ftw | input | PHASE_W | Phase step added per accepted sample |
| out_valid | output | 1 | Output sample is present this cycle |
| out_data | output | OUT_W | Real IF output, two's complement |

## Verification
The bench builds the block with its default parameters: 8-bit data, 10-bit output, a 32-bit accumulator, a 16-bit angle path and 12 stages. With these values the output is four times the input scale, so an 8-bit input at full scale, rotated to 45 degrees, goes past the 10-bit range and reaches saturation in both directions. Tuning words of 2^29 and 2^30 step through exact octant and quadrant angles and wrap the accumulator within a few samples. The 70 MHz word exercises residual angles that fall irregularly across all four quadrants. Gaps in `in_valid`, a change of tuning word in the middle of a stream, and a reset during a stream test how the phase and the output hold behave.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  // Fraction bits and value of the inverse CORDIC gain (1/1.64676)
  localparam int INV_GAIN_FRAC = 12;
  localparam int INV_GAIN_Q    = 2487;
  localparam int INV_GAIN_W    = INV_GAIN_FRAC + 1;
  localparam int MAX_STAGES    = 16;

  // atan(2^-i) as a fraction of a full turn, scaled by 2^32
  function automatic logic [31:0] atan_turn32(input int i);
    logic [31:0] r;
    case (i)
      0:       r = 32'h2000_0000;
      1:       r = 32'h12E4_051E;
      2:       r = 32'h09FB_385B;
      3:       r = 32'h0511_11D4;
      4:       r = 32'h028B_0D43;
      5:       r = 32'h0145_D7E1;
      6:       r = 32'h00A2_F61E;
      7:       r = 32'h0051_7C55;
      8:       r = 32'h0028_BE53;
      9:       r = 32'h0014_5F2F;
      10:      r = 32'h000A_2F98;
      11:      r = 32'h0005_17CC;
      12:      r = 32'h0002_8BE6;
      13:      r = 32'h0001_45F3;
      14:      r = 32'h0000_A2FA;
      15:      r = 32'h0000_517D;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmod_phase_acc.sv
module cmod_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [PHASE_W-1:0] step,
  output logic [ANG_W-1:0]   angle
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_d;

  // The current value is the phase of the sample now being accepted
  assign angle = acc_q[PHASE_W-1 -: ANG_W];

  always_comb begin
    acc_d = acc_q;
    if (step_en) begin
      acc_d = acc_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/cmod_quad_prerot.sv
module cmod_quad_prerot #(
  parameter int DATA_W = 8,
  parameter int IW     = 14,
  parameter int FRAC_W = 4,
  parameter int ANG_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  input  logic [ANG_W-1:0]        angle_i,
  output logic                    v_o,
  output logic signed [IW-1:0]    x_o,
  output logic signed [IW-1:0]    y_o,
  output logic signed [ANG_W-1:0] z_o
);

  logic signed [IW-1:0]    xe;
  logic signed [IW-1:0]    ye;
  logic signed [IW-1:0]    x_d;
  logic signed [IW-1:0]    y_d;
  logic signed [ANG_W-1:0] z_d;
  logic [1:0]              quad;

  assign quad = angle_i[ANG_W-1 -: 2];

  always_comb begin
    xe  = {{(IW-DATA_W){i_i[DATA_W-1]}}, i_i} <<< FRAC_W;
    ye  = {{(IW-DATA_W){q_i[DATA_W-1]}}, q_i} <<< FRAC_W;
    z_d = {2'b00, angle_i[ANG_W-3:0]};
    case (quad)
      2'd0: begin x_d = xe;  y_d = ye;  end
      2'd1: begin x_d = -ye; y_d = xe;  end
      2'd2: begin x_d = -xe; y_d = -ye; end
      default: begin x_d = ye; y_d = -xe; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else if (v_i) begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end

endmodule

// File: rtl/cmod_cordic_stage.sv
module cmod_cordic_stage
  import cmod_pkg::*;
#(
  parameter int IW    = 14,
  parameter int ANG_W = 16,
  parameter int SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic signed [IW-1:0]    x_i,
  input  logic signed [IW-1:0]    y_i,
  input  logic signed [ANG_W-1:0] z_i,
  output logic                    v_o,
  output logic signed [IW-1:0]    x_o,
  output logic signed [IW-1:0]    y_o,
  output logic signed [ANG_W-1:0] z_o
);

  localparam logic [31:0] ATAN_RAW = atan_turn32(SHIFT);
  localparam logic [31:0] ATAN_RND =
    (ATAN_RAW + (32'd1 << (31 - ANG_W))) >> (32 - ANG_W);
  localparam logic signed [ANG_W-1:0] ATAN_Z = ATAN_RND[ANG_W-1:0];

  logic signed [IW-1:0]    xs;
  logic signed [IW-1:0]    ys;
  logic signed [IW-1:0]    x_d;
  logic signed [IW-1:0]    y_d;
  logic signed [ANG_W-1:0] z_d;

  always_comb begin
    xs = x_i >>> SHIFT;
    ys = y_i >>> SHIFT;
    if (!z_i[ANG_W-1]) begin
      x_d = x_i - ys;
      y_d = y_i + xs;
      z_d = z_i - ATAN_Z;
    end else begin
      x_d = x_i + ys;
      y_d = y_i - xs;
      z_d = z_i + ATAN_Z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else if (v_i) begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end

endmodule

// File: rtl/cmod_out_scale.sv
module cmod_out_scale
  import cmod_pkg::*;
#(
  parameter int IW     = 14,
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic signed [IW-1:0]    x_i,
  output logic                    v_o,
  output logic signed [OUT_W-1:0] d_o
);

  localparam int PW = IW + INV_GAIN_W;
  localparam int SH = INV_GAIN_FRAC + FRAC_W - (OUT_W - DATA_W);
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (SH - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] GAIN = PW'(INV_GAIN_Q);

  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    rnd;
  logic signed [PW-1:0]    shifted;
  logic signed [OUT_W-1:0] d_d;

  always_comb begin
    prod    = $signed({{(PW-IW){x_i[IW-1]}}, x_i}) * GAIN;
    rnd     = prod + HALF;
    shifted = rnd >>> SH;
    if (shifted > MAXV) begin
      d_d = MAXV[OUT_W-1:0];
    end else if (shifted < MINV) begin
      d_d = MINV[OUT_W-1:0];
    end else begin
      d_d = shifted[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_o <= '0;
    end else if (v_i) begin
      d_o <= d_d;
    end
  end

endmodule

// File: rtl/cordic_if_mixer.sv
module cordic_if_mixer
  import cmod_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OUT_W   = 10,
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 16,
  parameter int STAGES  = 12,
  parameter int FRAC_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [PHASE_W-1:0]      ftw,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  // Two guard bits hold the CORDIC gain on a vector of length sqrt(2)
  localparam int IW  = DATA_W + 2 + FRAC_W;
  localparam int LAT = STAGES + 2;

  logic [ANG_W-1:0] angle;

  logic                    sv [STAGES];
  logic signed [IW-1:0]    sx [STAGES];
  logic signed [IW-1:0]    sy [STAGES];
  logic signed [ANG_W-1:0] sz [STAGES];

  logic                    fin_v;
  logic signed [IW-1:0]    fin_x;
  logic signed [IW-1:0]    unused_fin_y;
  logic signed [ANG_W-1:0] unused_fin_z;

  cmod_phase_acc #(
    .PHASE_W (PHASE_W),
    .ANG_W   (ANG_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (in_valid),
    .step    (ftw),
    .angle   (angle)
  );

  cmod_quad_prerot #(
    .DATA_W (DATA_W),
    .IW     (IW),
    .FRAC_W (FRAC_W),
    .ANG_W  (ANG_W)
  ) u_prerot (
    .clk     (clk),
    .rst_n   (rst_n),
    .v_i     (in_valid),
    .i_i     (in_i),
    .q_i     (in_q),
    .angle_i (angle),
    .v_o     (sv[0]),
    .x_o     (sx[0]),
    .y_o     (sy[0]),
    .z_o     (sz[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k < STAGES - 1) begin : g_mid
      cmod_cordic_stage #(
        .IW    (IW),
        .ANG_W (ANG_W),
        .SHIFT (k)
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (sv[k]),
        .x_i   (sx[k]),
        .y_i   (sy[k]),
        .z_i   (sz[k]),
        .v_o   (sv[k+1]),
        .x_o   (sx[k+1]),
        .y_o   (sy[k+1]),
        .z_o   (sz[k+1])
      );
    end else begin : g_last
      cmod_cordic_stage #(
        .IW    (IW),
        .ANG_W (ANG_W),
        .SHIFT (k)
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (sv[k]),
        .x_i   (sx[k]),
        .y_i   (sy[k]),
        .z_i   (sz[k]),
        .v_o   (fin_v),
        .x_o   (fin_x),
        .y_o   (unused_fin_y),
        .z_o   (unused_fin_z)
      );
    end
  end

  cmod_out_scale #(
    .IW     (IW),
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
  ) u_scale (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (fin_v),
    .x_i   (fin_x),
    .v_o   (out_valid),
    .d_o   (out_data)
  );

endmodule

// File: rtl/cmod_mixer_chk.sv
module cmod_mixer_chk #(
  parameter int LAT   = 14,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic [CW-1:0] inflight_q;
  logic [CW-1:0] inflight_d;

  always_comb begin
    inflight_d = inflight_q;
    if (in_valid && !out_valid) begin
      inflight_d = inflight_q + CW'(1);
    end else if (!in_valid && out_valid) begin
      inflight_d = inflight_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      inflight_q <= inflight_d;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R5
  no_orphan_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight_q != '0));

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CW'(LAT));

endmodule

bind cordic_if_mixer cmod_mixer_chk #(
  .LAT   (STAGES + 2),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_cordic_if_mixer.sv
module tb_cordic_if_mixer;

  localparam int CLK_PERIOD = 5;
  localparam int STAGES = 12;
  localparam int LAT = STAGES + 2;
  localparam int TOL = 2;
  localparam logic [31:0] FTW70 = 32'd1503238554;
  localparam int NV = 16;
  localparam int VEC_I [NV] = '{100, 0, -100, 50, 127, -128, 20, 64,
                                 -64, 1, 0, -1, 90, -70, 33, -5};
  localparam int VEC_Q [NV] = '{0, 100, 50, -100, 127, -128, -30, 64,
                                 32, 0, -1, -1, -45, -70, 77, 120};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_i;
  logic signed [7:0] in_q;
  logic [31:0]       ftw;
  logic              out_valid;
  logic signed [9:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int got = 0;
  int hold_err = 0;
  int prev_out = 0;
  int out_log [64];
  int s_i [32];
  int s_q [32];
  int s_gap [32];
  logic [31:0] s_f [32];
  int exp_v [32];

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  cordic_if_mixer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .ftw       (ftw),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (got < 64) out_log[got] = int'(out_data);
        got++;
      end else if (int'(out_data) != prev_out) begin
        hold_err++;
      end
      prev_out = int'(out_data);
    end
  end

  function automatic int model(int i, int q, longint p);
    real th, v;
    int r;
    th = 2.0 * 3.14159265358979 * real'(p) / 4294967296.0;
    v = 4.0 * (real'(i) * $cos(th) - real'(q) * $sin(th));
    r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_i = '0;
    in_q = '0;
    ftw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got = 0;
    hold_err = 0;
    prev_out = 0;
  endtask

  task automatic run_seq(int n, string tag);
    longint p = 0;
    got = 0;
    hold_err = 0;
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_i = 8'(s_i[k]);
      in_q = 8'(s_q[k]);
      ftw = s_f[k];
      exp_v[k] = model(s_i[k], s_q[k], p);
      p = (p + longint'(s_f[k])) % 64'd4294967296;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (s_gap[k]) @(negedge clk);
    end
    repeat (LAT + 3) @(negedge clk);
    // R5: one output per accepted sample
    check(got == n, {tag, " R5 count"}, got, n);
    for (int k = 0; k < n; k++) begin
      check((out_log[k] - exp_v[k] <= TOL) && (exp_v[k] - out_log[k] <= TOL),
            tag, out_log[k], exp_v[k]);
    end
    // R4: output holds while out_valid is low
    check(hold_err == 0, {tag, " R4 hold"}, hold_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first;
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_i = 8'sd100;
    in_q = 8'sd0;
    ftw = FTW70;
    repeat (4) @(negedge clk);
    // R1: quiet during reset even with input driven
    check(!out_valid, "R1 valid in reset", int'(out_valid), 0);
    check(out_data == 0, "R1 data in reset", int'(out_data), 0);

    do_reset();
    @(negedge clk);
    check(!out_valid && out_data == 0, "R1 after release", int'(out_data), 0);

    // R2: table walk at the 70 MHz tuning word
    for (int k = 0; k < NV; k++) begin
      s_i[k] = VEC_I[k]; s_q[k] = VEC_Q[k]; s_f[k] = FTW70; s_gap[k] = 0;
    end
    run_seq(NV, "R2 table");

    // R7 and R3: quarter-turn steps, wrapping the accumulator
    do_reset();
    for (int k = 0; k < 8; k++) begin
      s_i[k] = (k < 4) ? 100 : 0;
      s_q[k] = (k < 4) ? 0 : 100;
      s_f[k] = 32'h4000_0000;
      s_gap[k] = 0;
    end
    run_seq(8, "R7 quadrant R3 wrap");

    // R6: saturation at 45 and 225 degrees and at 180
    do_reset();
    s_i[0] = 0;    s_q[0] = 0;
    s_i[1] = 127;  s_q[1] = -128;
    s_i[2] = 0;    s_q[2] = 0;
    s_i[3] = 0;    s_q[3] = 0;
    s_i[4] = -128; s_q[4] = 0;
    s_i[5] = 127;  s_q[5] = -128;
    for (int k = 0; k < 6; k++) begin
      s_f[k] = 32'h2000_0000;
      s_gap[k] = 0;
    end
    run_seq(6, "R6 saturate");
    check(out_log[1] == 511, "R6 upper clamp", out_log[1], 511);
    check(out_log[5] == -512, "R6 lower clamp", out_log[5], -512);

    // R4: gaps in in_valid do not advance phase
    do_reset();
    for (int k = 0; k < 6; k++) begin
      s_i[k] = 100 - 30 * k; s_q[k] = 20 * k - 40; s_f[k] = FTW70;
    end
    s_gap[0] = 0; s_gap[1] = 3; s_gap[2] = 1;
    s_gap[3] = 5; s_gap[4] = 0; s_gap[5] = 2;
    run_seq(6, "R4 gaps");

    // R8: tuning word change applies to the step at its own edge
    do_reset();
    for (int k = 0; k < 4; k++) begin
      s_i[k] = 100; s_q[k] = 0; s_gap[k] = 0;
    end
    s_f[0] = 32'h4000_0000; s_f[1] = 32'h2000_0000;
    s_f[2] = 32'h1000_0000; s_f[3] = FTW70;
    run_seq(4, "R8 retune");

    // R5: fixed latency of a single sample
    do_reset();
    in_valid = 1'b1; in_i = 8'sd50; in_q = 8'sd0; ftw = '0;
    first = 0;
    for (int c = 1; c <= LAT + 4; c++) begin
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid && first == 0) first = c;
    end
    check(first == LAT, "R5 latency", first, LAT);
    check(got == 1, "R5 single output", got, 1);

    // R1: reset in the middle of a stream clears outputs and phase
    do_reset();
    in_valid = 1'b1; in_i = 8'sd100; in_q = 8'sd0; ftw = 32'h4000_0000;
    repeat (LAT + 2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!out_valid && out_data == 0, "R1 async clear", int'(out_data), 0);
    do_reset();
    for (int k = 0; k < 2; k++) begin
      s_i[k] = 100; s_q[k] = 0; s_f[k] = 32'h4000_0000; s_gap[k] = 0;
    end
    run_seq(2, "R1 phase cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule